// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block watches a free-running 16-bit timer value and compares it on every clock with a programmable 16-bit compare value. When the two first become equal, the unit performs the action chosen by a 4-bit mode held in its control register. It can drive the compare pin high, drive it low, leave the pin alone and only raise the interrupt flag, or emit a special event trigger.

The special event trigger sends a one-cycle reset pulse to the timer, so the compare value works as a period register. When the external converter is enabled, the trigger also sends a one-cycle conversion-start pulse. A reset caused by the trigger is not a timer rollover, so it never sets the timer-overflow flag. That flag is set only by the timer's own wrap pulse.

Writing zero to the control register turns compare off and forces the compare output latch low. A separate direction input decides whether the pin is driven. The timer, the converter and interrupt masking are outside this block.

Top module: `cmp_trigger_unit`

## Requirements
- R1: After reset, cmp_pin, cmp_flag, ovf_flag, tmr_reset and conv_start are all 0, and the mode is off (4'b0000).
- R2: In mode 4'b1000, a match sets cmp_pin to 1 at the clock edge where the match is seen.
- R3: In mode 4'b1001, a match clears cmp_pin to 0 at the clock edge where the match is seen.
- R4: In mode 4'b1010, a match leaves cmp_pin unchanged and sets cmp_flag.
- R5: In mode 4'b1011, a match gives tmr_reset = 1 for exactly one cycle and leaves cmp_pin unchanged.
- R6: conv_start pulses in the same cycle as tmr_reset, and only when conv_en is 1 at the match.
- R7: ovf_flag is set only by a tmr_wrap pulse. A tmr_reset from the trigger never sets it.
- R8: A control write (ctl_we = 1) with ctl_wdata = 4'b0000 forces cmp_pin to 0 at the next edge and disables compare.
- R9: A match is the first cycle of equality: tmr_val == cmp_val in that cycle and not in the previous one. Equality that is held produces only one match.
- R10: cmp_flag is set by a match in any of the four compare modes (4'b10xx). It stays set until cmp_flag_clr. A match in the same cycle as the clear wins.
- R11: cmp_oe equals drive_en (1 = pin driven). Modes outside 4'b10xx, including off, never produce a match.
- R12: ovf_clr clears ovf_flag. A wrap in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | 16 | Current timer value |
| cmp_val | input | 16 | Compare value |
| ctl_wdata | input | 4 | Mode to write into the control register |
| ctl_we | input | 1 | Control register write strobe |
| conv_en | input | 1 | External converter is enabled |
| drive_en | input | 1 | Direction bit, 1 = drive the pin |
| tmr_wrap | input | 1 | Timer natural rollover pulse |
| cmp_flag_clr | input | 1 | Clears the compare interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| cmp_pin | output | 1 | Compare output latch level |
| cmp_oe | output | 1 | Pin output enable |
| cmp_flag | output | 1 | Sticky compare interrupt flag |
| ovf_flag | output | 1 | Sticky timer-overflow flag |
| tmr_reset | output | 1 | One-cycle timer reset pulse |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
The assertions check these rules on every cycle:
- each timer-reset pulse lasts a single cycle;
- conversion start never occurs without a timer reset;
- the overflow flag is not set by a trigger;
- a zero control write leaves the pin low;
- the compare flag stays set until it is cleared;
- the software-interrupt mode holds the pin steady.

Some behaviour only the bench scenarios can show. These are the actual pin levels after matches in the set and clear modes, and the gating of conversion start by conv_en. They also include the fact that held equality yields only one match, and that the off mode and other non-compare encodings do nothing.

// File: rtl/cmp_trigger_unit.sv
module cmp_trigger_unit #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr_val,
  input  logic [TW-1:0] cmp_val,
  input  logic [3:0]    ctl_wdata,
  input  logic          ctl_we,
  input  logic          conv_en,
  input  logic          drive_en,
  input  logic          tmr_wrap,
  input  logic          cmp_flag_clr,
  input  logic          ovf_clr,
  output logic          cmp_pin,
  output logic          cmp_oe,
  output logic          cmp_flag,
  output logic          ovf_flag,
  output logic          tmr_reset,
  output logic          conv_start
);

  localparam logic [3:0] M_OFF  = 4'b0000;
  localparam logic [3:0] M_SET  = 4'b1000;
  localparam logic [3:0] M_CLR  = 4'b1001;
  localparam logic [3:0] M_SWI  = 4'b1010;
  localparam logic [3:0] M_TRIG = 4'b1011;

  logic [3:0] mode;
  logic       eq, eq_q, cmp_on, hit;

  assign eq     = (tmr_val == cmp_val);
  assign cmp_on = (mode[3:2] == 2'b10);
  assign hit    = cmp_on && eq && !eq_q;
  assign cmp_oe = drive_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= M_OFF;
      eq_q       <= 1'b0;
      cmp_pin    <= 1'b0;
      cmp_flag   <= 1'b0;
      ovf_flag   <= 1'b0;
      tmr_reset  <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      eq_q       <= eq;
      tmr_reset  <= hit && (mode == M_TRIG);
      conv_start <= hit && (mode == M_TRIG) && conv_en;

      if (ctl_we) mode <= ctl_wdata;

      if (ctl_we && ctl_wdata == M_OFF) cmp_pin <= 1'b0;
      else if (hit && mode == M_SET)    cmp_pin <= 1'b1;
      else if (hit && mode == M_CLR)    cmp_pin <= 1'b0;

      if (hit)               cmp_flag <= 1'b1;
      else if (cmp_flag_clr) cmp_flag <= 1'b0;

      if (tmr_wrap)     ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_reset |=> !tmr_reset); // R5

  AST_CONV_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> tmr_reset); // R6

  AST_NO_OVF_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_reset && !ovf_flag && !tmr_wrap) |=> !ovf_flag); // R7

  AST_ZERO_WRITE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata == M_OFF) |=> !cmp_pin); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !cmp_flag_clr) |=> cmp_flag); // R10

  AST_SWI_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SWI && !ctl_we) |=> $stable(cmp_pin)); // R4

endmodule

// File: tb/cmp_trigger_unit_test.sv
`timescale 1ns/1ps
module cmp_trigger_unit_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] tmr_val = 0, cmp_val = 16'hFFFF;
  logic [3:0] ctl_wdata = 0;
  logic ctl_we = 0, conv_en = 0, drive_en = 0, tmr_wrap = 0, cmp_flag_clr = 0, ovf_clr = 0;
  logic cmp_pin, cmp_oe, cmp_flag, ovf_flag, tmr_reset, conv_start;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp_trigger_unit uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] t);
    @(negedge clk);
    tmr_val = t;
    @(posedge clk); #1;
    ctl_we = 0; cmp_flag_clr = 0; ovf_clr = 0; tmr_wrap = 0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = m; tmr_val = 16'h0001; cmp_val = 16'h0300;
    @(posedge clk); #1;
    ctl_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 pin", cmp_pin, 0); chk("R1 flag", cmp_flag, 0);
    chk("R1 ovf", ovf_flag, 0); chk("R1 trst", tmr_reset, 0);
    chk("R1 conv", conv_start, 0);
  endtask

  task automatic t_set_and_hold;
    set_mode(4'b1000);
    cmp_val = 16'd100;
    step(16'd99);
    chk("R2 pin before match", cmp_pin, 0);
    step(16'd100);
    chk("R2 pin high", cmp_pin, 1);
    chk("R10 flag set", cmp_flag, 1);
    cmp_flag_clr = 1; step(16'd100);
    chk("R9 held equality no rematch", cmp_flag, 0);
    step(16'd100);
    chk("R9 still no rematch", cmp_flag, 0);
  endtask

  task automatic t_clear;
    set_mode(4'b1001);
    cmp_val = 16'd201;
    step(16'd200);
    chk("R3 pin still high", cmp_pin, 1);
    step(16'd201);
    chk("R3 pin low", cmp_pin, 0);
    chk("R10 flag in clr mode", cmp_flag, 1);
    step(16'd202);
    chk("R10 flag sticky", cmp_flag, 1);
  endtask

  task automatic t_swi;
    set_mode(4'b1000); cmp_val = 16'd50; step(16'd49); step(16'd50);
    cmp_flag_clr = 1; step(16'd51);
    chk("R4 flag cleared", cmp_flag, 0);
    set_mode(4'b1010); cmp_val = 16'd60; step(16'd59); step(16'd60);
    chk("R4 pin unchanged", cmp_pin, 1);
    chk("R4 flag set", cmp_flag, 1);
  endtask

  task automatic t_trigger;
    set_mode(4'b1011); conv_en = 0; cmp_val = 16'd70;
    step(16'd69); step(16'd70);
    chk("R5 trst pulse", tmr_reset, 1);
    chk("R6 no conv when disabled", conv_start, 0);
    chk("R5 pin unchanged", cmp_pin, 1);
    chk("R7 no ovf from trigger", ovf_flag, 0);
    step(16'd0);
    chk("R5 trst one cycle", tmr_reset, 0);
    conv_en = 1;
    step(16'd69); step(16'd70);
    chk("R6 conv with trst", conv_start, 1);
    chk("R6 trst", tmr_reset, 1);
    step(16'd0);
    chk("R6 conv one cycle", conv_start, 0);
    chk("R7 still no ovf", ovf_flag, 0);
  endtask

  task automatic t_ovf;
    tmr_wrap = 1; step(16'd5);
    chk("R7 wrap sets ovf", ovf_flag, 1);
    ovf_clr = 1; tmr_wrap = 1; step(16'd6);
    chk("R12 wrap beats clear", ovf_flag, 1);
    ovf_clr = 1; step(16'd7);
    chk("R12 clear", ovf_flag, 0);
  endtask

  task automatic t_zero_and_off;
    chk("R8 pin high before zero write", cmp_pin, 1);
    set_mode(4'b0000);
    chk("R8 pin forced low", cmp_pin, 0);
    cmp_flag_clr = 1; step(16'd1);
    cmp_val = 16'd9; step(16'd8); step(16'd9);
    chk("R11 off mode no match", cmp_flag, 0);
    set_mode(4'b1100); cmp_val = 16'd9; step(16'd8); step(16'd9);
    chk("R11 non-compare mode no match", cmp_flag, 0);
    set_mode(4'b0001); step(16'd8); step(16'd9);
    chk("R11 mode 0001 no match", cmp_flag, 0);
  endtask

  task automatic t_clear_race_and_oe;
    set_mode(4'b1010); cmp_val = 16'd30; step(16'd29);
    cmp_flag_clr = 1; step(16'd30);
    chk("R10 set wins over clear", cmp_flag, 1);
    drive_en = 1; #1;
    chk("R11 oe on", cmp_oe, 1);
    drive_en = 0; #1;
    chk("R11 oe off", cmp_oe, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_set_and_hold();
    t_clear();
    t_swi();
    t_trigger();
    t_ovf();
    t_zero_and_off();
    t_clear_race_and_oe();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule